// File: doc/BRIEF.md
# Max-star unit with gated correction table

This block evaluates the Jacobian logarithm ln(e^a + e^b) for the add-compare stages of an iterative soft-decision channel decoder. It returns the larger of its two operands plus a small positive correction that approximates ln(1 + e^-|a-b|). The correction comes from a constant table, and the table address is the magnitude of the operand gap.

Large gaps make the correction vanish. The block compares the gap against a cutoff of 5.0 in the same cycle that it forms the gap. When the gap is above the cutoff, the table's read enable stays low, so no table access happens, and the final adder takes a constant zero in place of the table output.

Operands are 12-bit two's-complement numbers with 3 fractional bits, so one LSB is 1/8. Results come out two cycles after the operands, with one new operation accepted every cycle. A per-result flag reports whether that operation read the table, so surrounding logic can count gated and ungated operations.

Top module: `maxstar_unit`

## Requirements
- R1: For a valid operation with |a-b| <= 40 LSB (5.0), out_res equals max(a,b) + T[floor(|a-b|/2)], where the table T holds correction values in LSB. T[0..11] = 6,5,4,3,3,2,2,1,1,1,1,0 and every higher entry is 0.
- R2: For a valid operation with |a-b| > 40 LSB, out_res equals max(a,b) exactly, out_acc is 0, and the table output register does not change.
- R3: A gap of exactly 40 LSB (5.0) still reads the table: out_acc is 1 and the correction is T[20].
- R4: out_valid rises exactly two clock edges after the edge that samples in_valid high, and stays low two edges after an idle cycle.
- R5: out_acc is high only in cycles where out_valid is high.
- R6: out_res is 13 bits wide, so the full operand range plus the largest correction (2047+6 and -2048+6) comes out without wrap-around.
- R7: While rst is high, and on the first cycles after it, out_valid and out_acc are 0.
- R8: The result does not depend on operand order: swapping a and b gives the same out_res and out_acc, including for negative operands.
- R9: Back-to-back valid operands on consecutive cycles each produce their own result on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is present this cycle |
| in_a | input | 12 | First metric, signed, 3 fractional bits |
| in_b | input | 12 | Second metric, signed, 3 fractional bits |
| out_valid | output | 1 | Result is present this cycle |
| out_res | output | 13 | max*(a,b), signed, 3 fractional bits |
| out_acc | output | 1 | The correction table was read for this result |

## Verification
A wrong gate decision shows up at the ports on the second edge after the operands arrive. The out_acc flag takes the wrong value, and for gaps of 5.0 or less the result also loses its correction. An off-by-one in the table address or a stale table register shifts out_res by one or more LSB in that same cycle, and the sweep over every gap from 0 to 47 LSB exposes it. A mis-staged valid or accessed flag shows as a result that arrives on the wrong cycle, or as out_acc without out_valid. Both are caught as soon as the first affected operation leaves the pipeline.

// File: rtl/maxstar_pkg.sv
package maxstar_pkg;

    localparam int MS_DW      = 12;   // operand width
    localparam int MS_FRAC    = 3;    // fractional bits
    localparam int MS_CUT_INT = 5;    // gating cutoff, integer units
    localparam int MS_IDX_FB  = 2;    // fractional bits kept in the table index
    localparam int MS_CW      = 4;    // correction word width

    localparam int MS_SHIFT = MS_FRAC - MS_IDX_FB;
    localparam int MS_CUT   = MS_CUT_INT << MS_FRAC;
    localparam int MS_DEPTH = (MS_CUT_INT + 1) << MS_IDX_FB;
    localparam int MS_IW    = $clog2(MS_DEPTH);
    localparam int MS_RW    = MS_DW + 1;

    typedef logic signed [MS_DW-1:0] op_t;
    typedef logic signed [MS_RW-1:0] res_t;
    typedef logic [MS_DW:0]          gap_t;
    typedef logic [MS_IW-1:0]        idx_t;
    typedef logic [MS_CW-1:0]        corr_t;

    typedef struct packed {
        logic vld;
        logic rd;
        op_t  mx;
    } s1_t;

    // ln(1 + exp(-x)) in 1/8 units, sampled at x = idx/4
    function automatic corr_t corr_lut(input idx_t i);
        corr_t v;
        case (int'(i))
            0:             v = corr_t'(6);
            1:             v = corr_t'(5);
            2:             v = corr_t'(4);
            3, 4:          v = corr_t'(3);
            5, 6:          v = corr_t'(2);
            7, 8, 9, 10:   v = corr_t'(1);
            default:       v = corr_t'(0);
        endcase
        return v;
    endfunction

    function automatic gap_t gap_mag(input logic signed [MS_DW:0] d);
        return d[MS_DW] ? gap_t'(-d) : gap_t'(d);
    endfunction

endpackage

// File: rtl/maxstar_front.sv
module maxstar_front
    import maxstar_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  op_t  in_a,
    input  op_t  in_b,
    output logic rd_en,
    output idx_t rd_idx,
    output s1_t  s1_q
);
    logic signed [MS_DW:0] diff;
    gap_t gap;
    op_t  mx;

    always_comb begin
        diff   = {in_a[MS_DW-1], in_a} - {in_b[MS_DW-1], in_b};
        gap    = gap_mag(diff);
        mx     = diff[MS_DW] ? in_b : in_a;
        rd_en  = in_valid && (gap <= gap_t'(MS_CUT));
        rd_idx = gap[MS_IW+MS_SHIFT-1:MS_SHIFT];
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= '{vld: in_valid, rd: rd_en, mx: mx};
    end

    // R2: a read is issued only for a valid operation
    p_read_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
        s1_q.rd |-> s1_q.vld);

endmodule

// File: rtl/maxstar_rom.sv
module maxstar_rom
    import maxstar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    output corr_t corr_q
);
    always_ff @(posedge clk) begin
        if (rst)        corr_q <= '0;
        else if (rd_en) corr_q <= corr_lut(rd_idx);
    end

    // R2: a gated cycle leaves the table output untouched
    p_gated_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(corr_q));

endmodule

// File: rtl/maxstar_back.sv
module maxstar_back
    import maxstar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  s1_t   s1_q,
    input  corr_t corr_q,
    output logic  out_valid,
    output logic  out_acc,
    output res_t  out_res
);
    res_t mx_ext;
    res_t add;

    always_comb begin
        mx_ext = res_t'(s1_q.mx);
        add    = s1_q.rd ? res_t'({1'b0, corr_q}) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_acc   <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= s1_q.vld;
            out_acc   <= s1_q.vld && s1_q.rd;
            out_res   <= mx_ext + add;
        end
    end

    // R2: a gated valid operation passes the maximum through unchanged
    p_zero_corr_r2: assert property (@(posedge clk) disable iff (rst)
        (s1_q.vld && !s1_q.rd) |=> (out_res == $past(mx_ext)));

endmodule

// File: rtl/maxstar_unit.sv
module maxstar_unit
    import maxstar_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic signed [11:0] in_a,
    input  logic signed [11:0] in_b,
    output logic              out_valid,
    output logic signed [12:0] out_res,
    output logic              out_acc
);
    logic  rd_en;
    idx_t  rd_idx;
    s1_t   s1_q;
    corr_t corr_q;

    maxstar_front u_front (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .rd_en(rd_en), .rd_idx(rd_idx), .s1_q(s1_q)
    );

    maxstar_rom u_rom (
        .clk(clk), .rst(rst), .rd_en(rd_en), .rd_idx(rd_idx), .corr_q(corr_q)
    );

    maxstar_back u_back (
        .clk(clk), .rst(rst), .s1_q(s1_q), .corr_q(corr_q),
        .out_valid(out_valid), .out_acc(out_acc), .out_res(out_res)
    );

    gap_t in_gap;
    always_comb in_gap = gap_mag({in_a[11], in_a} - {in_b[11], in_b});

    // R5: the accessed flag only accompanies a result
    p_acc_valid_r5: assert property (@(posedge clk) disable iff (rst)
        out_acc |-> out_valid);

    // R4: two-cycle latency
    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    // R4: idle input gives idle output
    p_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // R3: gaps up to and including the cutoff read the table
    p_cut_inclusive_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_gap <= gap_t'(MS_CUT)) |-> ##2 out_acc);

endmodule

// File: tb/maxstar_unit_bench.sv
module maxstar_unit_bench;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [11:0] in_a = '0;
    logic signed [11:0] in_b = '0;
    logic out_valid;
    logic signed [12:0] out_res;
    logic out_acc;

    maxstar_unit u_maxstar_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_res(out_res), .out_acc(out_acc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    cyc;
        int    res;
        bit    acc;
        string req;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    bit done   = 1'b0;
    int tbl [24];

    always @(posedge clk) cycle <= cycle + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic drive(input int a, input int b, input string req);
        exp_t e;
        int d, g, mx;
        @(negedge clk);
        in_valid = 1'b1;
        in_a = 12'(a);
        in_b = 12'(b);
        d  = a - b;
        g  = (d < 0) ? -d : d;
        mx = (a > b) ? a : b;
        e.cyc = cycle + 2;
        e.req = req;
        if (g > 40) begin
            e.res = mx; e.acc = 1'b0;
        end else begin
            e.res = mx + tbl[g / 2]; e.acc = 1'b1;
        end
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (out_acc && !out_valid)
                    chk(1'b0, "R5", "acc_without_valid", 1, 0);
                if (out_valid) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R4", "unexpected_result", int'(out_res), 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(int'(out_res) == e.res, e.req, "result", int'(out_res), e.res);
                        chk(out_acc == e.acc, e.req, "accessed", int'(out_acc), int'(e.acc));
                        chk(cycle == e.cyc, "R4", "latency", cycle, e.cyc);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 24; i++) tbl[i] = 0;
        tbl[0] = 6; tbl[1] = 5; tbl[2] = 4; tbl[3] = 3; tbl[4] = 3;
        tbl[5] = 2; tbl[6] = 2; tbl[7] = 1; tbl[8] = 1; tbl[9] = 1; tbl[10] = 1;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "valid_in_reset", int'(out_valid), 0);
        chk(out_acc == 1'b0, "R7", "acc_in_reset", int'(out_acc), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R7", "valid_after_reset", int'(out_valid), 0);
        chk(out_acc == 1'b0, "R7", "acc_after_reset", int'(out_acc), 0);

        // R1: corrected results
        drive(0, 0, "R1");
        drive(16, 8, "R1");
        drive(-20, -25, "R1");
        idle(2);
        // R8: operand order
        drive(3, 5, "R8");
        drive(5, 3, "R8");
        drive(-30, -50, "R8");
        drive(-50, -30, "R8");
        idle(1);
        // R3: cutoff inclusive
        drive(40, 0, "R3");
        drive(0, 40, "R3");
        // R2: gated
        drive(41, 0, "R2");
        drive(0, -41, "R2");
        drive(100, 50, "R2");
        drive(2047, -2048, "R2");
        drive(-2048, 2047, "R2");
        idle(3);
        // R6: extremes without wrap
        drive(2047, 2047, "R6");
        drive(-2048, -2048, "R6");
        drive(2047, 2046, "R6");
        // R9: back-to-back sweep over every gap
        for (int g = 0; g < 48; g++) drive(g - 10, -10, "R9");
        idle(4);

        chk(sb.size() == 0, "R4", "pending_results", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule